// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block sits in the memory path of a host bridge and classifies each CPU access that falls in the legacy window between 640 KB and 1 MB. Each access goes to one of three places: system DRAM with reads and writes allowed, system DRAM that may only be read, or the expansion bus. The classification comes from a set of 2-bit attribute fields held in a small byte-wide register file, together with a system-management-mode input that gates the video window.

The legacy window has three parts. The 128 KB video range is normally forwarded to the bus. A management gate can open it onto DRAM, either unconditionally or only while management mode is active. The 192 KB expansion range is cut into equal 16 KB segments, each with its own attribute field, and the fields are packed two to a byte. The top 64 KB BIOS range has one field of its own. Addresses outside the legacy window always go to DRAM. A write aimed at a read-only segment is flagged so that the memory side can drop it.

The register file accepts byte writes at the attribute offsets and at the management gate offset. Writes to any other offset are ignored. The decoded target and the drop flag come out of registers one clock after the access is presented.

Top module: `shadow_decode_top`

## Requirements
- R1: An access whose address is below 0xA0000 or at or above 0x100000 yields target code 2'b00 (DRAM read/write), and drop_wr stays 0.
- R2: Accesses in 0xF0000–0xFFFFF take their attribute from bits [5:4] of the byte at offset 0x59.
- R3: 0xC0000–0xEFFFF is split into 12 segments of 16 KB. Segment i (counted from 0xC0000) takes its attribute from the byte at offset 0x5A + (i>>1): bits [1:0] when i is even, bits [5:4] when i is odd. The other bits of these bytes have no effect.
- R4: The attribute maps to a target code as follows: attribute 3 gives 2'b00 (DRAM read/write), attribute 1 gives 2'b01 (DRAM read-only), and attributes 0 and 2 give 2'b10 (expansion bus). Code 2'b11 is never produced.
- R5: drop_wr is 1 exactly when the access is a write (acc_wr=1) and its target code is 2'b01.
- R6: 0xA0000–0xBFFFF yields 2'b00 when bit 6 of the byte at offset 0x72 is set, or when smm_active is 1 and bit 3 of that byte is set. Otherwise it yields 2'b10.
- R7: A synchronous active-high reset clears all attribute fields to 0 and loads 0x02 into the offset 0x72 byte. On the clock edge after reset is sampled, the outputs read 2'b10 with drop_wr=0.
- R8: The outputs present at a clock edge reflect the address, acc_wr and smm_active sampled at that edge, decoded with the configuration committed before that edge. A configuration write at an edge therefore first affects the access decoded at the following edge. A change of smm_active takes effect with no register write.
- R9: A configuration write (cfg_we=1) to any offset other than 0x59–0x5F and 0x72 changes no decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W (32) | Physical address of the CPU access |
| acc_wr | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | System management mode is active |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| tgt | output | 2 | Registered target code: 00 DRAM r/w, 01 DRAM read-only, 10 bus |
| drop_wr | output | 1 | Registered flag: write to a read-only target, to be dropped |

## Verification
The checker watches on every cycle that addresses outside the legacy window land on read/write DRAM, that the drop flag only comes with a read-only target after a write, that code 2'b11 never appears, and that reset forces the bus target. It also tracks the gate byte from the write port, so it can check the video window decode whenever the window is open or closed. The per-segment nibble selection, the exact segment boundaries under each of the four encodings, the one-cycle delay before a register write takes effect, and the ignoring of writes to foreign offsets rest on the bench's behavioural model. That model is compared on every clock against directed sweeps and random traffic.

// File: rtl/shd_pkg.sv
package shd_pkg;

  // Target codes seen at the tgt port
  typedef enum logic [1:0] {
    TGT_DRAM_RW = 2'b00,
    TGT_DRAM_RO = 2'b01,
    TGT_BUS     = 2'b10
  } tgt_e;

  localparam int ATTR_W = 2;

  // 2-bit attribute field to target code
  function automatic tgt_e attr_to_tgt(input logic [ATTR_W-1:0] attr);
    tgt_e t;
    case (attr)
      2'd3:    t = TGT_DRAM_RW;
      2'd1:    t = TGT_DRAM_RO;
      default: t = TGT_BUS;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/shd_cfg_regs.sv
// Byte-write register file holding the unpacked attribute fields and the
// management gate byte. Field 0 belongs to the BIOS range, field 1+i to
// expansion segment i.
module shd_cfg_regs
  import shd_pkg::*;
#(
  parameter int         NUM_SEG    = 12,
  parameter logic [7:0] ATTR_OFF   = 8'h59,
  parameter logic [7:0] GATE_OFF   = 8'h72,
  parameter logic [7:0] GATE_RST   = 8'h02,
  localparam int        NUM_FLD    = NUM_SEG + 1,
  localparam int        NUM_PAIR   = (NUM_SEG + 1) / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_off,
  input  logic [7:0]             cfg_wdata,
  output logic [ATTR_W-1:0]      fld_q [NUM_FLD],
  output logic [7:0]             gate_q
);

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[7:6], cfg_wdata[3:2]};

  // BIOS range field, upper nibble of the first attribute byte
  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q[0] <= '0;
    end else if (cfg_we && cfg_off == ATTR_OFF) begin
      fld_q[0] <= cfg_wdata[5:4];
    end
  end

  // One byte per pair of segments: even segment in the low nibble
  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    localparam logic [7:0] PAIR_OFF = ATTR_OFF + 8'(k + 1);
    localparam int         EVEN_IDX = 1 + 2 * k;
    localparam int         ODD_IDX  = 2 + 2 * k;

    always_ff @(posedge clk) begin
      if (rst) begin
        fld_q[EVEN_IDX] <= '0;
      end else if (cfg_we && cfg_off == PAIR_OFF) begin
        fld_q[EVEN_IDX] <= cfg_wdata[1:0];
      end
    end

    if (ODD_IDX < NUM_FLD) begin : g_odd
      always_ff @(posedge clk) begin
        if (rst) begin
          fld_q[ODD_IDX] <= '0;
        end else if (cfg_we && cfg_off == PAIR_OFF) begin
          fld_q[ODD_IDX] <= cfg_wdata[5:4];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= GATE_RST;
    end else if (cfg_we && cfg_off == GATE_OFF) begin
      gate_q <= cfg_wdata;
    end
  end

endmodule

// File: rtl/shd_seg_decode.sv
// Address to attribute field lookup for the expansion and BIOS ranges.
module shd_seg_decode
  import shd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SEG   = 12,
  parameter int SEG_LOG2  = 14,
  parameter int EXP_BASE  = 32'h000C_0000,
  parameter int BIOS_BASE = 32'h000F_0000,
  parameter int TOP_ADDR  = 32'h0010_0000,
  localparam int NUM_FLD  = NUM_SEG + 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ATTR_W-1:0]  fld_q [NUM_FLD],
  output logic               hit,
  output logic [ATTR_W-1:0]  attr
);

  localparam logic [ADDR_W-1:0] SEG_SIZE = ADDR_W'(1) << SEG_LOG2;
  localparam logic [ADDR_W-1:0] BIOS_LO  = ADDR_W'(BIOS_BASE);
  localparam logic [ADDR_W-1:0] TOP_LO   = ADDR_W'(TOP_ADDR);

  logic [NUM_SEG-1:0]    seg_hit;
  logic [ATTR_W-1:0]     seg_attr [NUM_SEG];
  logic                  bios_hit;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(EXP_BASE) + ADDR_W'(i) * SEG_SIZE;
    localparam logic [ADDR_W-1:0] HI = LO + SEG_SIZE;
    assign seg_hit[i]  = (addr >= LO) && (addr < HI);
    assign seg_attr[i] = seg_hit[i] ? fld_q[i + 1] : '0;
  end

  assign bios_hit = (addr >= BIOS_LO) && (addr < TOP_LO);

  always_comb begin
    attr = bios_hit ? fld_q[0] : '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      attr = attr | seg_attr[i];
    end
  end

  assign hit = bios_hit || (|seg_hit);

endmodule

// File: rtl/shd_vga_gate.sv
// Video window detection and management-mode gate.
module shd_vga_gate #(
  parameter int ADDR_W   = 32,
  parameter int VGA_BASE = 32'h000A_0000,
  parameter int EXP_BASE = 32'h000C_0000,
  parameter int OPEN_BIT = 6,
  parameter int SMM_BIT  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm_active,
  input  logic [7:0]        gate_q,
  output logic              in_win,
  output logic              win_open
);

  localparam logic [ADDR_W-1:0] LO = ADDR_W'(VGA_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(EXP_BASE);

  logic unused_gate;
  assign unused_gate = ^{gate_q[7], gate_q[5:4], gate_q[2:0]};

  assign in_win   = (addr >= LO) && (addr < HI);
  assign win_open = gate_q[OPEN_BIT] || (smm_active && gate_q[SMM_BIT]);

endmodule

// File: rtl/shadow_decode_top.sv
module shadow_decode_top
  import shd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SEG   = 12,
  parameter int SEG_LOG2  = 14,
  parameter int VGA_BASE  = 32'h000A_0000,
  parameter int EXP_BASE  = 32'h000C_0000,
  parameter int BIOS_BASE = 32'h000F_0000,
  parameter int TOP_ADDR  = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_off,
  input  logic [7:0]        cfg_wdata,
  output logic [1:0]        tgt,
  output logic              drop_wr
);

  localparam int NUM_FLD = NUM_SEG + 1;

  logic [ATTR_W-1:0] fld_q [NUM_FLD];
  logic [7:0]        gate_q;
  logic              seg_hit;
  logic [ATTR_W-1:0] seg_attr;
  logic              in_win;
  logic              win_open;
  tgt_e              tgt_d;
  tgt_e              tgt_q;
  logic              drop_q;

  shd_cfg_regs #(
    .NUM_SEG (NUM_SEG)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_off   (cfg_off),
    .cfg_wdata (cfg_wdata),
    .fld_q     (fld_q),
    .gate_q    (gate_q)
  );

  shd_seg_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_SEG   (NUM_SEG),
    .SEG_LOG2  (SEG_LOG2),
    .EXP_BASE  (EXP_BASE),
    .BIOS_BASE (BIOS_BASE),
    .TOP_ADDR  (TOP_ADDR)
  ) u_seg (
    .addr  (acc_addr),
    .fld_q (fld_q),
    .hit   (seg_hit),
    .attr  (seg_attr)
  );

  shd_vga_gate #(
    .ADDR_W   (ADDR_W),
    .VGA_BASE (VGA_BASE),
    .EXP_BASE (EXP_BASE)
  ) u_gate (
    .addr       (acc_addr),
    .smm_active (smm_active),
    .gate_q     (gate_q),
    .in_win     (in_win),
    .win_open   (win_open)
  );

  always_comb begin
    if (in_win) begin
      tgt_d = win_open ? TGT_DRAM_RW : TGT_BUS;
    end else if (seg_hit) begin
      tgt_d = attr_to_tgt(seg_attr);
    end else begin
      tgt_d = TGT_DRAM_RW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= TGT_BUS;
      drop_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      drop_q <= acc_wr && (tgt_d == TGT_DRAM_RO);
    end
  end

  assign tgt     = tgt_q;
  assign drop_wr = drop_q;

endmodule

// File: rtl/shd_chk.sv
module shd_chk #(
  parameter int ADDR_W    = 32,
  parameter int VGA_BASE  = 32'h000A_0000,
  parameter int EXP_BASE  = 32'h000C_0000,
  parameter int TOP_ADDR  = 32'h0010_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic              smm_active,
  input logic              cfg_we,
  input logic [7:0]        cfg_off,
  input logic [7:0]        cfg_wdata,
  input logic [1:0]        tgt,
  input logic              drop_wr
);

  localparam logic [ADDR_W-1:0] VLO = ADDR_W'(VGA_BASE);
  localparam logic [ADDR_W-1:0] VHI = ADDR_W'(EXP_BASE);
  localparam logic [ADDR_W-1:0] THI = ADDR_W'(TOP_ADDR);

  // Shadow of the gate byte, tracked from the write port
  logic [7:0] gate_seen;
  always_ff @(posedge clk) begin
    if (rst) gate_seen <= 8'h02;
    else if (cfg_we && cfg_off == 8'h72) gate_seen <= cfg_wdata;
  end

  logic outside, in_win, win_open;
  assign outside  = (acc_addr < VLO) || (acc_addr >= THI);
  assign in_win   = (acc_addr >= VLO) && (acc_addr < VHI);
  assign win_open = gate_seen[6] || (smm_active && gate_seen[3]);

  // R1
  outside_dram_chk: assert property (@(posedge clk) disable iff (rst)
    outside |=> (tgt == 2'b00 && !drop_wr));

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    tgt != 2'b11);

  // R5
  drop_needs_ro_chk: assert property (@(posedge clk) disable iff (rst)
    drop_wr |-> (tgt == 2'b01 && $past(acc_wr)));

  // R6
  win_open_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && win_open) |=> (tgt == 2'b00));

  // R6
  win_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (in_win && !win_open) |=> (tgt == 2'b10));

  // R7
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (tgt == 2'b10 && !drop_wr));

endmodule

bind shadow_decode_top shd_chk #(
  .ADDR_W   (ADDR_W),
  .VGA_BASE (VGA_BASE),
  .EXP_BASE (EXP_BASE),
  .TOP_ADDR (TOP_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_addr   (acc_addr),
  .acc_wr     (acc_wr),
  .smm_active (smm_active),
  .cfg_we     (cfg_we),
  .cfg_off    (cfg_off),
  .cfg_wdata  (cfg_wdata),
  .tgt        (tgt),
  .drop_wr    (drop_wr)
);

// File: tb/sim_shadow_decode_top.sv
`timescale 1ns/1ps
module sim_shadow_decode_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic        smm_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  tgt;
  logic        drop_wr;

  always #2.5 clk = ~clk;

  shadow_decode_top u0 (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .smm_active(smm_active), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .tgt(tgt), .drop_wr(drop_wr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural model state: raw bytes by offset
  int unsigned mbyte [256];
  int unsigned exp_t;
  int unsigned exp_d;
  string       exp_req;
  string       force_req = "";

  function automatic int unsigned attr_code(int unsigned a);
    if (a == 3) return 0;       // R4 read/write
    if (a == 1) return 1;       // R4 read-only
    return 2;                   // R4 bus
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) mbyte[i] = 0;
    mbyte[8'h72] = 8'h02;
  endfunction

  function automatic void model_eval(int unsigned a, bit wr, bit smm);
    int unsigned seg;
    int unsigned b;
    if (a >= 32'hA0000 && a < 32'hC0000) begin
      exp_req = "R6";
      if ((mbyte[8'h72] & 8'h40) != 0 || (smm && (mbyte[8'h72] & 8'h08) != 0)) exp_t = 0;
      else exp_t = 2;
    end else if (a >= 32'hC0000 && a < 32'hF0000) begin
      exp_req = "R3";
      seg = (a - 32'hC0000) / 16384;
      b = mbyte[8'h5A + seg / 2];
      exp_t = attr_code((seg % 2 == 1) ? ((b >> 4) & 3) : (b & 3));
    end else if (a >= 32'hF0000 && a < 32'h100000) begin
      exp_req = "R2";
      exp_t = attr_code((mbyte[8'h59] >> 4) & 3);
    end else begin
      exp_req = "R1";
      exp_t = 0;
    end
    exp_d = (wr && exp_t == 1) ? 1 : 0;
  endfunction

  task automatic cyc(input int unsigned a, input bit wr, input bit smm,
                     input bit we = 0, input int unsigned off = 0,
                     input int unsigned dat = 0);
    string tag;
    acc_addr = a; acc_wr = wr; smm_active = smm;
    cfg_we = we; cfg_off = off[7:0]; cfg_wdata = dat[7:0];
    @(posedge clk);
    // R8: decode uses the configuration committed before this edge
    if (rst) begin
      exp_t = 2; exp_d = 0; exp_req = "R7";
      model_reset();
    end else begin
      model_eval(a, wr, smm);
      if (we && ((off >= 8'h59 && off <= 8'h5F) || off == 8'h72))
        mbyte[off] = dat & 8'hFF;
    end
    @(negedge clk);
    tag = (force_req != "") ? force_req : exp_req;
    total++;
    if (tgt !== exp_t[1:0]) begin
      bad++;
      $display("FAIL %s tgt addr=%h act=%b exp=%0d", tag, a, tgt, exp_t);
    end
    total++;
    if (drop_wr !== exp_d[0]) begin
      bad++;
      $display("FAIL R5 drop addr=%h act=%b exp=%0d", a, drop_wr, exp_d);
    end
    cfg_we = 0;
  endtask

  task automatic wcfg(input int unsigned off, input int unsigned dat);
    cyc(32'h0, 0, 0, 1, off, dat);
  endtask

  // Every segment edge plus window and region limits, read and write
  task automatic sweep(input bit smm);
    for (int i = 0; i < 12; i++) begin
      int unsigned lo = 32'hC0000 + i * 16384;
      cyc(lo, 0, smm); cyc(lo, 1, smm);
      cyc(lo + 16383, 0, smm); cyc(lo + 16383, 1, smm);
    end
    cyc(32'hF0000, 0, smm); cyc(32'hF0000, 1, smm);
    cyc(32'hFFFFF, 1, smm); cyc(32'hFFFFF, 0, smm);
    cyc(32'h9FFFF, 1, smm); cyc(32'h100000, 1, smm);
    cyc(32'hA0000, 1, smm); cyc(32'hBFFFF, 0, smm);
    cyc(32'hFFFFFFFF, 1, smm);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    // R7: reset state
    cyc(32'hC0000, 1, 0);
    cyc(32'h0, 0, 0);
    rst = 0;
    // R7: attributes zero -> whole shadow region forwards
    sweep(0);

    // R4: each encoding replicated in every field
    for (int e = 0; e < 4; e++) begin
      wcfg(8'h59, e << 4);
      for (int k = 0; k < 6; k++) wcfg(8'h5A + k, (e << 4) | e);
      sweep(0);
      sweep(1);
    end

    // R3: distinct fields, junk in the unused bits of each byte
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 7; k++) wcfg(8'h59 + k, $urandom & 8'hFF);
      sweep(n % 2);
    end

    // R6: gate combinations with smm toggling and no register write
    for (int g = 0; g < 4; g++) begin
      wcfg(8'h72, ((g & 2) ? 8'h40 : 0) | ((g & 1) ? 8'h08 : 0) | 8'h02);
      for (int s = 0; s < 2; s++) begin
        cyc(32'hA0000, 0, s[0]); cyc(32'hB1234, 1, s[0]);
        cyc(32'hBFFFF, 1, !s[0]); cyc(32'hC0000, 0, s[0]);
      end
    end

    // R8: write lands one access later
    cyc(32'hC4000, 1, 0, 1, 8'h5A, 8'h10);
    cyc(32'hC4000, 1, 0);
    cyc(32'hC4000, 1, 0, 1, 8'h5A, 8'h30);
    cyc(32'hC4000, 1, 0);

    // R9: foreign offsets must change nothing
    force_req = "R9";
    wcfg(8'h59, 8'h10);
    for (int k = 0; k < 6; k++) wcfg(8'h5A + k, 8'h11);
    wcfg(8'h72, 8'h00);
    foreach (mbyte[o]) begin
      if (!((o >= 8'h59 && o <= 8'h5F) || o == 8'h72)) begin
        cyc(32'hA0000, 0, 1, 1, o, 8'hFF);
      end
    end
    sweep(1);
    force_req = "";

    // Mixed random traffic with occasional writes
    for (int n = 0; n < 3000; n++) begin
      int unsigned a = 32'h90000 + ($urandom % 32'h80000);
      int unsigned r = $urandom % 10;
      if (r == 0) cyc(a, $urandom % 2, $urandom % 2, 1, 8'h59 + ($urandom % 7), $urandom & 8'hFF);
      else if (r == 1) cyc(a, $urandom % 2, $urandom % 2, 1, 8'h72, $urandom & 8'hFF);
      else cyc(a, $urandom % 2, $urandom % 2);
    end

    // R7: reset in mid-run restores defaults
    rst = 1;
    cyc(32'hF0000, 1, 1);
    rst = 0;
    sweep(1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule